// File: doc/BRIEF.md
# Wishbone Sliced Register Slave

This block is a Wishbone classic slave that owns a single internal register and connects it to local logic. The register is between 1 and 32 bits wide and never wider than the bus data path. A parameter picks its access direction: the bus may read it only, write it only, or do both. On the local side the register can be cut into contiguous, non-overlapping bit fields. Each field gets its own lane on a packed output bus, with its bits moved down to bit 0. With no fields defined, lane 0 carries the whole register. Register bits that fall in no field are still stored, but they drive no local output.

The bus has no address: any strobed cycle addresses this register. The handshake is the single-cycle classic form. The request (`wb_cyc_i` and `wb_stb_i` both high) is the valid, and `wb_ack_o` is the ready/completion. The slave accepts a request on the first clock edge that samples it while `wb_ack_o` is low, and it raises `wb_ack_o` for exactly that one following cycle. The master applies back-pressure only by holding its request off. It must drop or renew the strobe in the cycle that shows the acknowledge, because a strobe still held in that cycle is not taken as a new request. Local logic can load the register through a plain load strobe, so a read-only register can still report a value.

Top module: `wb_slice_reg`

## Requirements
- R1: A synchronous reset clears the register, `wb_ack_o`, `wb_dat_o` and every field lane to zero.
- R2: When `wb_cyc_i` and `wb_stb_i` are both high at a clock edge while `wb_ack_o` is low, `wb_ack_o` is high for exactly the one cycle after that edge.
- R3: In read/write or write-only mode, an accepted request with `wb_we_i` high loads the register from `wb_dat_i[REG_W-1:0]` at the accepting edge. Higher data bits are ignored.
- R4: An accepted read in read/write or read-only mode returns the register in the acknowledge cycle, zero-extended to `DATA_W`. In write-only mode a read is acknowledged and returns zero.
- R5: In read-only mode a bus write is acknowledged but leaves the register unchanged.
- R6: `hw_ld_i` high at an edge loads the register from `hw_dat_i`. When an effective bus write is accepted at the same edge, the bus value wins.
- R7: Field lane i (`field_o[i*REG_W +: REG_W]`) holds register bits `SLICE_HI[i]` down to `SLICE_LO[i]` (8-bit entries of the packed bound vectors), with the low bound at bit 0 and zeros above. The lanes change at the same edge as the register.
- R8: With `SLICE_N` = 0 there is one lane, and it carries the whole register.
- R9: Register bits covered by no field appear on no lane, but they are still read back over the bus.
- R10: `wb_stb_i` without `wb_cyc_i` is ignored: there is no acknowledge and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Strobe, qualifies the transfer |
| wb_we_i | input | 1 | High for a write |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data, valid while acknowledged |
| wb_ack_o | output | 1 | One-cycle transfer acknowledge |
| hw_ld_i | input | 1 | Local load strobe |
| hw_dat_i | input | REG_W | Local load value |
| field_o | output | FIELD_N*REG_W | Field lanes, each zero-extended to REG_W |

## Verification
Bus results are due exactly one edge after the request is sampled. The acknowledge, the read data and the new register contents (seen through the field lanes) all settle after that edge. The bench checks them 2 ns after it, while the request is still held. It then checks one edge later that the acknowledge has dropped. A local load shows on the lanes after the edge that samples it. Read data is compared by a monitor against a queue filled by the driver when the request is issued. Unchanged and ignored cases are confirmed by reading the register back after the stimulus.

// File: rtl/wbsr_pkg.sv
package wbsr_pkg;
  typedef enum logic [1:0] {
    ACC_RW = 2'd0,
    ACC_RO = 2'd1,
    ACC_WO = 2'd2
  } access_e;

  localparam int unsigned SLICE_MAX = 8;
  localparam int unsigned BOUND_W   = 8;
endpackage

// File: rtl/wbsr_bus_ack.sv
module wbsr_bus_ack (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cyc_i,
  input  logic stb_i,
  input  logic we_i,
  output logic ack_o,
  output logic wr_take_o,
  output logic rd_take_o
);
  logic take;

  assign take      = cyc_i && stb_i && !ack_o;
  assign wr_take_o = take && we_i;
  assign rd_take_o = take && !we_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) ack_o <= 1'b0;
    else       ack_o <= take;
  end

  assert_ack_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o);
  assert_ack_cause_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !(cyc_i && stb_i) |=> !ack_o);
endmodule

// File: rtl/wbsr_store.sv
module wbsr_store #(
  parameter int unsigned      DATA_W = 32,
  parameter int unsigned      REG_W  = 8,
  parameter wbsr_pkg::access_e ACCESS = wbsr_pkg::ACC_RW
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_take_i,
  input  logic              rd_take_i,
  input  logic [DATA_W-1:0] bus_dat_i,
  input  logic              hw_ld_i,
  input  logic [REG_W-1:0]  hw_dat_i,
  output logic [REG_W-1:0]  q_o,
  output logic [DATA_W-1:0] rd_dat_o
);
  localparam bit BUS_WR = (ACCESS != wbsr_pkg::ACC_RO);
  localparam bit BUS_RD = (ACCESS != wbsr_pkg::ACC_WO);

  logic bus_wr_eff;
  assign bus_wr_eff = wr_take_i && BUS_WR;

  always_ff @(posedge clk_i) begin
    if (rst_i)           q_o <= '0;
    else if (bus_wr_eff) q_o <= bus_dat_i[REG_W-1:0];
    else if (hw_ld_i)    q_o <= hw_dat_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                    rd_dat_o <= '0;
    else if (rd_take_i && BUS_RD) rd_dat_o <= DATA_W'(q_o);
    else                          rd_dat_o <= '0;
  end

  generate
    if (BUS_WR) begin : g_wr_chk
      assert_bus_load_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_take_i |=> q_o == $past(bus_dat_i[REG_W-1:0]));
    end else begin : g_ro_chk
      assert_ro_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !hw_ld_i |=> $stable(q_o));
    end
    if (BUS_RD) begin : g_rd_chk
      assert_read_data_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_take_i |=> rd_dat_o == DATA_W'($past(q_o)));
    end else begin : g_wo_chk
      assert_wo_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_take_i |=> rd_dat_o == '0);
    end
  endgenerate
endmodule

// File: rtl/wbsr_field_map.sv
module wbsr_field_map #(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned SLICE_N = 2,
  parameter int unsigned FIELD_N = 2,
  parameter logic [wbsr_pkg::SLICE_MAX*wbsr_pkg::BOUND_W-1:0] SLICE_LO = '0,
  parameter logic [wbsr_pkg::SLICE_MAX*wbsr_pkg::BOUND_W-1:0] SLICE_HI = '0
) (
  input  logic [REG_W-1:0]         q_i,
  output logic [FIELD_N*REG_W-1:0] field_o
);
  localparam int unsigned BW = wbsr_pkg::BOUND_W;

  generate
    if (SLICE_N == 0) begin : g_whole
      assign field_o = q_i;
    end else begin : g_slices
      for (genvar i = 0; i < SLICE_N; i++) begin : g_lane
        localparam int unsigned LO = int'(SLICE_LO[i*BW +: BW]);
        localparam int unsigned HI = int'(SLICE_HI[i*BW +: BW]);
        assign field_o[i*REG_W +: REG_W] = REG_W'(q_i[HI:LO]);
      end
    end
  endgenerate
endmodule

// File: rtl/wb_slice_reg.sv
module wb_slice_reg #(
  parameter int unsigned       DATA_W  = 32,
  parameter int unsigned       REG_W   = 8,
  parameter wbsr_pkg::access_e ACCESS  = wbsr_pkg::ACC_RW,
  parameter int unsigned       SLICE_N = 2,
  parameter logic [wbsr_pkg::SLICE_MAX*wbsr_pkg::BOUND_W-1:0] SLICE_LO = 64'h0000_0000_0000_0400,
  parameter logic [wbsr_pkg::SLICE_MAX*wbsr_pkg::BOUND_W-1:0] SLICE_HI = 64'h0000_0000_0000_0703,
  localparam int unsigned      FIELD_N = (SLICE_N == 0) ? 1 : SLICE_N
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     wb_cyc_i,
  input  logic                     wb_stb_i,
  input  logic                     wb_we_i,
  input  logic [DATA_W-1:0]        wb_dat_i,
  output logic [DATA_W-1:0]        wb_dat_o,
  output logic                     wb_ack_o,
  input  logic                     hw_ld_i,
  input  logic [REG_W-1:0]         hw_dat_i,
  output logic [FIELD_N*REG_W-1:0] field_o
);
  logic             wr_take, rd_take;
  logic [REG_W-1:0] q;

  wbsr_bus_ack u_ack (
    .clk_i(clk_i), .rst_i(rst_i), .cyc_i(wb_cyc_i), .stb_i(wb_stb_i),
    .we_i(wb_we_i), .ack_o(wb_ack_o), .wr_take_o(wr_take), .rd_take_o(rd_take)
  );

  wbsr_store #(.DATA_W(DATA_W), .REG_W(REG_W), .ACCESS(ACCESS)) u_store (
    .clk_i(clk_i), .rst_i(rst_i), .wr_take_i(wr_take), .rd_take_i(rd_take),
    .bus_dat_i(wb_dat_i), .hw_ld_i(hw_ld_i), .hw_dat_i(hw_dat_i),
    .q_o(q), .rd_dat_o(wb_dat_o)
  );

  wbsr_field_map #(.REG_W(REG_W), .SLICE_N(SLICE_N), .FIELD_N(FIELD_N),
                   .SLICE_LO(SLICE_LO), .SLICE_HI(SLICE_HI)) u_map (
    .q_i(q), .field_o(field_o)
  );

  assert_local_load_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (hw_ld_i && !(wr_take && ACCESS != wbsr_pkg::ACC_RO)) |=> q == $past(hw_dat_i));
endmodule

// File: tb/wb_slice_reg_tb_top.sv
module wb_slice_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0]  cyc = '0;
  logic        stb = 1'b0, we = 1'b0;
  logic [31:0] dat = '0;
  logic [2:0]  hw_ld = '0;
  logic [15:0] hw_dat = '0;
  logic [31:0] dout0, dout1, dout2;
  logic [2:0]  ack;
  logic [15:0] fld0;
  logic [11:0] fld1;
  logic [15:0] fld2;

  wb_slice_reg dut_i (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc[0]), .wb_stb_i(stb), .wb_we_i(we),
    .wb_dat_i(dat), .wb_dat_o(dout0), .wb_ack_o(ack[0]),
    .hw_ld_i(hw_ld[0]), .hw_dat_i(hw_dat[7:0]), .field_o(fld0));

  wb_slice_reg #(.REG_W(12), .ACCESS(wbsr_pkg::ACC_RO), .SLICE_N(1),
                 .SLICE_LO(64'h02), .SLICE_HI(64'h09)) dut_ro_i (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc[1]), .wb_stb_i(stb), .wb_we_i(we),
    .wb_dat_i(dat), .wb_dat_o(dout1), .wb_ack_o(ack[1]),
    .hw_ld_i(hw_ld[1]), .hw_dat_i(hw_dat[11:0]), .field_o(fld1));

  wb_slice_reg #(.REG_W(16), .ACCESS(wbsr_pkg::ACC_WO), .SLICE_N(0)) dut_wo_i (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc[2]), .wb_stb_i(stb), .wb_we_i(we),
    .wb_dat_i(dat), .wb_dat_o(dout2), .wb_ack_o(ack[2]),
    .hw_ld_i(hw_ld[2]), .hw_dat_i(hw_dat), .field_o(fld2));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] rd_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dsel(input int s);
    return (s == 0) ? dout0 : (s == 1) ? dout1 : dout2;
  endfunction

  // Driver: one classic cycle; a read on the main unit queues its expected data.
  task automatic bus(input int s, input bit w, input logic [31:0] d,
                     input logic [31:0] exp_rd, output logic [31:0] got);
    @(negedge clk);
    cyc[s] = 1'b1; stb = 1'b1; we = w; dat = d;
    if (!w && s == 0) rd_q.push_back(exp_rd);
    @(posedge clk); #2;
    chk(ack[s] == 1'b1, "R2 ack rise", 32'(ack[s]), 32'd1);
    got = dsel(s);
    @(negedge clk);
    cyc[s] = 1'b0; stb = 1'b0; we = 1'b0;
    @(posedge clk); #2;
    chk(ack[s] == 1'b0, "R2 ack single", 32'(ack[s]), 32'd0);
  endtask

  task automatic hwload(input int s, input logic [15:0] d);
    @(negedge clk);
    hw_ld[s] = 1'b1; hw_dat = d;
    @(negedge clk);
    hw_ld[s] = 1'b0;
  endtask

  // Monitor: scoreboard for main-unit read data in the acknowledge cycle.
  always begin
    @(posedge clk); #2;
    if (!rst && ack[0] && !we && cyc[0]) begin
      if (rd_q.size() == 0) chk(1'b0, "R4 unexpected read ack", dout0, 32'h0);
      else begin
        logic [31:0] e;
        e = rd_q.pop_front();
        chk(dout0 == e, "R4 readback zero-extended", dout0, e);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(ack == 3'b000, "R1 ack reset", 32'(ack), 32'h0);
    chk(fld0 == 16'h0, "R1 fields reset", 32'(fld0), 32'h0);
    chk(dout0 == 32'h0, "R1 data reset", dout0, 32'h0);

    // main unit: read/write, lanes 3..0 and 7..4
    bus(0, 1'b1, 32'h0000_00A5, 32'h0, g);
    chk(fld0 == 16'h0A05, "R3 R7 lanes after write", 32'(fld0), 32'h0A05);
    bus(0, 1'b0, 32'h0, 32'h0000_00A5, g);
    bus(0, 1'b1, 32'hFFFF_FF3C, 32'h0, g);
    chk(fld0 == 16'h030C, "R3 upper data ignored", 32'(fld0), 32'h030C);
    bus(0, 1'b0, 32'h0, 32'h0000_003C, g);

    // R10: strobe without cycle
    @(negedge clk); stb = 1'b1; we = 1'b1; dat = 32'h0000_0011;
    @(posedge clk); #2;
    chk(ack == 3'b000, "R10 no ack without cyc", 32'(ack), 32'h0);
    @(negedge clk); stb = 1'b0; we = 1'b0;
    chk(fld0 == 16'h030C, "R10 register unchanged", 32'(fld0), 32'h030C);

    // R6: local load, then conflict with a bus write
    hwload(0, 16'h0077);
    chk(fld0 == 16'h0707, "R6 local load", 32'(fld0), 32'h0707);
    @(negedge clk);
    hw_ld[0] = 1'b1; hw_dat = 16'h0011;
    cyc[0] = 1'b1; stb = 1'b1; we = 1'b1; dat = 32'h0000_0022;
    @(posedge clk); #2;
    chk(ack[0] == 1'b1, "R2 ack on conflict write", 32'(ack[0]), 32'd1);
    @(negedge clk); hw_ld[0] = 1'b0; cyc[0] = 1'b0; stb = 1'b0; we = 1'b0;
    chk(fld0 == 16'h0202, "R6 bus write wins", 32'(fld0), 32'h0202);
    bus(0, 1'b0, 32'h0, 32'h0000_0022, g);

    // read-only unit, single lane bits 9..2
    hwload(1, 16'h0FFF);
    chk(fld1 == 12'h0FF, "R7 narrow lane", 32'(fld1), 32'h0FF);
    bus(1, 1'b0, 32'h0, 32'h0, g);
    chk(g == 32'h0000_0FFF, "R4 read-only readback", g, 32'h0FFF);
    bus(1, 1'b1, 32'h0000_0000, 32'h0, g);
    bus(1, 1'b0, 32'h0, 32'h0, g);
    chk(g == 32'h0000_0FFF, "R5 write ignored", g, 32'h0FFF);
    hwload(1, 16'h0C03);
    chk(fld1 == 12'h000, "R9 uncovered bits off lane", 32'(fld1), 32'h000);
    bus(1, 1'b0, 32'h0, 32'h0, g);
    chk(g == 32'h0000_0C03, "R9 uncovered bits read back", g, 32'h0C03);

    // write-only unit, no fields
    bus(2, 1'b1, 32'h1234_BEEF, 32'h0, g);
    chk(fld2 == 16'hBEEF, "R8 whole register lane", 32'(fld2), 32'hBEEF);
    bus(2, 1'b0, 32'h0, 32'h0, g);
    chk(g == 32'h0, "R4 write-only reads zero", g, 32'h0);

    // R1: reset clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(fld0 == 16'h0 && fld1 == 12'h0 && fld2 == 16'h0, "R1 reset clears",
        32'(fld2), 32'h0);
    chk(rd_q.size() == 0, "R4 all reads answered", 32'(rd_q.size()), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule